// File: doc/BRIEF.md
# Single-Channel Timer with Edge Capture

This block is one timer channel with a 16-bit down-counter, configured and observed through a small register port. It has three operating modes. In one-shot mode it counts down once and raises a timeout. In periodic mode it counts down, reloads and repeats. In edge-capture mode the counter keeps running, and the count is stored whenever a chosen transition appears on an external pin.

Software programs the mode, a reload value and a control word, then sets the enable bit. A debug-halt input can freeze the counter, but only when the stall bit allows it. Each timeout toggles an output pin, and a control bit can invert that pin. The mode and the control fields are locked while the channel is enabled, so the configuration cannot change under a running count.

Register map, with a 2-bit address:

| Address | Register |
|---------|----------|
| 0 | Mode |
| 1 | Control |
| 2 | Reload value |
| 3 | Captured count (read-only) |

Top module: `gp_timer_chan`

## Requirements
- R1: After reset, all four registers read 0, and `tmo_irq`, `cap_flag` and `tmr_out` are 0.
- R2: Mode value 1 is one-shot. The enabling write, at clock edge e0, loads the reload value L. `tmo_irq` is high for exactly one cycle, after edge e0+L+1. The enable bit (control bit 0) clears in that same edge, and no further timeout follows.
- R3: Mode value 2 is periodic. The first timeout appears after edge e0+L+1, and each later one follows L+1 cycles after the previous one. Each timeout in one-shot or periodic mode toggles the output state.
- R4: Mode value 3 is edge capture. The counter runs through L down to 0 and back to L without raising timeouts. `cap_in` passes through two synchronizing flops. For a change sampled first at edge c1, the count held after edge c1+1 is stored at edge c1+2 into address 3, and `cap_flag` is set at that edge. Setting the enable bit clears `cap_flag`. Writes to address 3 are ignored.
- R5: Control bits 3:2 select the capture edge: 0 is rising, 1 is falling and 3 is both. Transitions that were not selected store nothing.
- R6: When the stall bit (control bit 1) is 1, each cycle with `dbg_halt` high holds the counter and delays the timeout by one cycle.
- R7: When the stall bit is 0, `dbg_halt` has no effect on timing.
- R8: `tmr_out` is the output state XOR control bit 6.
- R9: While enabled, writes to address 0 are ignored. A write to address 1 changes only bit 0.
- R10: Control reads back as {bit6 invert, bits3:2 edge, bit1 stall, bit0 enable}, and all other bits read 0.
- R11: Mode value 0, or edge code 2 in capture mode, leaves the channel idle: no timeout and no capture.
- R12: Clearing the enable bit in periodic mode stops the timeouts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture pin |
| dbg_halt | input | 1 | Debug halt request |
| tmo_irq | output | 1 | One-cycle timeout pulse |
| cap_flag | output | 1 | Capture-event flag |
| tmr_out | output | 1 | Toggling timer output |

## Verification
The bench builds the block at the default 16-bit count width. It keeps reload values between 2 and 100, so that many full one-shot and periodic periods fit in a short run. A capture run with a reload of 3 makes the counter wrap several times before the capture edge, which exercises the capture formula across the reload boundary. At this width, the control layout also keeps bits 15:7 of the control word visible, so that they can be checked to read zero.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int CTRL_BITS = 7;

    typedef enum logic [1:0] {
        MODE_RSVD     = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_PERIODIC = 2'd2,
        MODE_CAPTURE  = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RSVD = 2'd2,
        EDGE_ANY  = 2'd3
    } tedge_e;

    typedef struct packed {
        logic   inv;
        tedge_e edge_sel;
        logic   stall;
        logic   en;
    } tctrl_s;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_LOAD = 2'd2;
    localparam logic [1:0] A_CAPT = 2'd3;

    function automatic logic edge_hit(tedge_e sel, logic cur, logic prev);
        case (sel)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_ANY:  return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic mode_runs(tmode_e m, tedge_e e);
        return (m != MODE_RSVD) && !((m == MODE_CAPTURE) && (e == EDGE_RSVD));
    endfunction
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    input  logic          oneshot_done,
    input  logic [CW-1:0] cap_val,
    output logic [CW-1:0] rdata,
    output tmode_e        mode,
    output tctrl_s        ctrl,
    output logic [CW-1:0] load_val,
    output logic          start
);
    localparam int PADC = CW - CTRL_BITS;
    localparam int PADM = CW - 2;

    tmode_e        mode_q;
    tctrl_s        ctrl_q;
    logic [CW-1:0] load_q;

    assign start = wr && (addr == A_CTRL) && !ctrl_q.en && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RSVD;
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (wr && addr == A_MODE && !ctrl_q.en)
                mode_q <= tmode_e'(wdata[1:0]);
            if (wr && addr == A_LOAD)
                load_q <= wdata;
            if (wr && addr == A_CTRL) begin
                if (!ctrl_q.en) begin
                    ctrl_q.inv      <= wdata[6];
                    ctrl_q.edge_sel <= tedge_e'(wdata[3:2]);
                    ctrl_q.stall    <= wdata[1];
                end
                ctrl_q.en <= wdata[0];
            end
            if (oneshot_done)
                ctrl_q.en <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = {{PADM{1'b0}}, mode_q};
            A_CTRL:  rdata = {{PADC{1'b0}}, ctrl_q.inv, 2'b00, ctrl_q.edge_sel,
                              ctrl_q.stall, ctrl_q.en};
            A_LOAD:  rdata = load_q;
            default: rdata = cap_val;
        endcase
    end

    assign mode     = mode_q;
    assign ctrl     = ctrl_q;
    assign load_val = load_q;

    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.en |=> ($stable(mode_q) && $stable(ctrl_q.inv) &&
                       $stable(ctrl_q.edge_sel) && $stable(ctrl_q.stall)));
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  tmode_e        mode,
    input  tctrl_s        ctrl,
    input  logic [CW-1:0] load_val,
    input  logic          start,
    input  logic          dbg_halt,
    output logic [CW-1:0] cnt,
    output logic          tmo_irq,
    output logic          oneshot_done,
    output logic          tmr_out
);
    logic [CW-1:0] cnt_q;
    logic          tmo_q;
    logic          out_q;
    logic          run;
    logic          frozen;
    logic          step;
    logic          at_zero;

    assign run     = ctrl.en && mode_runs(mode, ctrl.edge_sel);
    assign frozen  = ctrl.stall && dbg_halt;
    assign step    = run && !frozen && !start;
    assign at_zero = (cnt_q == '0);
    assign oneshot_done = step && at_zero && (mode == MODE_ONESHOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tmo_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (start) begin
                cnt_q <= load_val;
            end else if (step) begin
                if (!at_zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    case (mode)
                        MODE_ONESHOT: begin
                            tmo_q <= 1'b1;
                            out_q <= ~out_q;
                        end
                        MODE_PERIODIC: begin
                            cnt_q <= load_val;
                            tmo_q <= 1'b1;
                            out_q <= ~out_q;
                        end
                        default: cnt_q <= load_val;
                    endcase
                end
            end
        end
    end

    assign cnt     = cnt_q;
    assign tmo_irq = tmo_q;
    assign tmr_out = out_q ^ ctrl.inv;

    assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.stall && dbg_halt && !start) |=> $stable(cnt_q));
    assert_oneshot_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (tmo_q && mode == MODE_ONESHOT) |-> !ctrl.en);
    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (tmo_q && mode == MODE_PERIODIC) |-> (cnt_q == $past(load_val)));
    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        tmo_q |-> $past(mode_runs(mode, ctrl.edge_sel)));
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_in,
    input  logic          arm,
    input  tedge_e        edge_sel,
    input  logic          clr,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] cap_val,
    output logic          cap_flag
);
    logic          s1, s2, prev;
    logic          hit;
    logic [CW-1:0] cap_q;
    logic          flag_q;

    assign hit = arm && edge_hit(edge_sel, s2, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            prev   <= 1'b0;
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            s1   <= cap_in;
            s2   <= s1;
            prev <= s2;
            if (clr)
                flag_q <= 1'b0;
            if (hit) begin
                cap_q  <= cnt;
                flag_q <= 1'b1;
            end
        end
    end

    assign cap_val  = cap_q;
    assign cap_flag = flag_q;

    assert_flag_from_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(arm));
    assert_idle_no_capture_R11: assert property (@(posedge clk) disable iff (rst)
        !arm |=> $stable(cap_q));
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan
    import gpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          cap_in,
    input  logic          dbg_halt,
    output logic          tmo_irq,
    output logic          cap_flag,
    output logic          tmr_out
);
    tmode_e        mode;
    tctrl_s        ctrl;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cap_val;
    logic          start;
    logic          oneshot_done;
    logic          arm;

    assign arm = ctrl.en && (mode == MODE_CAPTURE) && (ctrl.edge_sel != EDGE_RSVD);

    gpt_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .oneshot_done(oneshot_done), .cap_val(cap_val), .rdata(reg_rdata),
        .mode(mode), .ctrl(ctrl), .load_val(load_val), .start(start)
    );

    gpt_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .mode(mode), .ctrl(ctrl), .load_val(load_val),
        .start(start), .dbg_halt(dbg_halt), .cnt(cnt), .tmo_irq(tmo_irq),
        .oneshot_done(oneshot_done), .tmr_out(tmr_out)
    );

    gpt_capture #(.CW(CW)) u_cap (
        .clk(clk), .rst(rst), .cap_in(cap_in), .arm(arm), .edge_sel(ctrl.edge_sel),
        .clr(start), .cnt(cnt), .cap_val(cap_val), .cap_flag(cap_flag)
    );
endmodule

// File: tb/gp_timer_chan_tb.sv
module gp_timer_chan_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          cap_in = 1'b0;
    logic          dbg_halt = 1'b0;
    logic          tmo_irq, cap_flag, tmr_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tog = 0;
    int e0;

    gp_timer_chan #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
        .dbg_halt(dbg_halt), .tmo_irq(tmo_irq), .cap_flag(cap_flag),
        .tmr_out(tmr_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cap(int l, int n);
        return l - (n % (l + 1));
    endfunction

    task automatic wr_reg(logic [1:0] a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = CW'(d);
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    // returns posedge index at which tmo_irq was set, or -1
    task automatic wait_irq(int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (tmo_irq) begin at = cyc; break; end
        end
    endtask

    task automatic setup(int m, int l, int ctl);
        wr_reg(2'd1, 0);
        wr_reg(2'd0, m);
        wr_reg(2'd2, l);
        wr_reg(2'd1, ctl | 1);
        e0 = cyc;
    endtask

    task automatic drive_cap(logic v, output int x);
        @(negedge clk);
        cap_in = v;
        x = cyc;
    endtask

    initial begin
        int d, at, at2, x, l, m, inv, prevcap;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), d);
            check("R1 reg reset", d, 0);
        end
        check("R1 irq", int'(tmo_irq), 0);
        check("R1 flag", int'(cap_flag), 0);
        check("R1 out", int'(tmr_out), 0);

        // R10 / R11 / R9: all-ones control with reserved mode 0
        wr_reg(2'd1, 16'hFFFF);
        rd_reg(2'd1, d);
        check("R10 ctrl layout", d, 16'h004F);
        wait_irq(30, at);
        check("R11 mode0 idle", at, -1);
        check("R8 invert with no toggles", int'(tmr_out), 1);
        wr_reg(2'd1, 0);
        rd_reg(2'd1, d);
        check("R9 only enable cleared", d, 16'h004E);

        // R2 one-shot directed
        setup(1, 5, 0);
        wait_irq(40, at);
        check("R2 oneshot time", at, e0 + 6);
        tog++;
        rd_reg(2'd1, d);
        check("R2 enable cleared", d & 1, 0);
        wait_irq(30, at);
        check("R2 no second timeout", at, -1);
        check("R3 out toggled", int'(tmr_out), tog % 2);

        // R3 periodic + R9 locking + R12 stop
        setup(2, 7, 0);
        wait_irq(40, at);
        check("R3 first period", at, e0 + 8);
        tog++;
        wr_reg(2'd0, 1);
        wr_reg(2'd1, 16'h004F);
        rd_reg(2'd0, d);
        check("R9 mode locked", d, 2);
        rd_reg(2'd1, d);
        check("R9 ctrl locked", d, 16'h0001);
        wait_irq(40, at2);
        check("R3 second period", at2, at + 8);
        tog++;
        check("R3 out", int'(tmr_out), tog % 2);
        wr_reg(2'd1, 0);
        wait_irq(40, at);
        check("R12 stopped", at, -1);

        // R6 stall with halt
        setup(2, 10, 16'h0002);
        @(negedge clk); dbg_halt = 1'b1;
        repeat (4) @(negedge clk);
        dbg_halt = 1'b0;
        wait_irq(40, at);
        check("R6 stall delays", at, e0 + 15);
        tog++;
        wr_reg(2'd1, 0);
        // R7 halt without stall
        setup(2, 10, 0);
        @(negedge clk); dbg_halt = 1'b1;
        repeat (4) @(negedge clk);
        dbg_halt = 1'b0;
        wait_irq(40, at);
        check("R7 halt ignored", at, e0 + 11);
        tog++;
        wr_reg(2'd1, 0);
        check("R3 out after stall runs", int'(tmr_out), tog % 2);

        // random one-shot / periodic runs
        for (int k = 0; k < 8; k++) begin
            m = 1 + int'($urandom % 2);
            l = 2 + int'($urandom % 39);
            inv = int'($urandom % 2);
            setup(m, l, inv << 6);
            wait_irq(100, at);
            check(m == 1 ? "R2 random oneshot" : "R3 random periodic", at, e0 + l + 1);
            tog++;
            if (m == 2) begin
                wait_irq(100, at2);
                check("R3 random period", at2, at + l + 1);
                tog++;
                wr_reg(2'd1, inv << 6);
            end
            check("R8 random out", int'(tmr_out), (tog % 2) ^ inv);
        end

        // R4 / R5 capture rising edge
        setup(3, 100, 0);
        repeat (5) @(negedge clk);
        check("R4 no timeout in capture", int'(tmo_irq), 0);
        drive_cap(1'b1, x);
        repeat (3) @(posedge clk);
        rd_reg(2'd3, d);
        check("R4 rise capture", d, exp_cap(100, x + 2 - e0));
        check("R4 flag set", int'(cap_flag), 1);
        prevcap = d;
        wr_reg(2'd3, 16'h1234);
        rd_reg(2'd3, d);
        check("R4 capture read-only", d, prevcap);
        drive_cap(1'b0, x);
        repeat (4) @(posedge clk);
        rd_reg(2'd3, d);
        check("R5 falling ignored on rise", d, prevcap);

        // falling edge
        drive_cap(1'b1, x);
        setup(3, 100, 1 << 2);
        check("R4 flag cleared on enable", int'(cap_flag), 0);
        repeat (4) @(negedge clk);
        drive_cap(1'b0, x);
        repeat (3) @(posedge clk);
        rd_reg(2'd3, d);
        check("R5 fall capture", d, exp_cap(100, x + 2 - e0));

        // both edges, with wrap (L=3)
        setup(3, 3, 3 << 2);
        repeat (int'($urandom % 20) + 3) @(negedge clk);
        drive_cap(1'b1, x);
        repeat (3) @(posedge clk);
        rd_reg(2'd3, d);
        check("R5 both rise, wrapped", d, exp_cap(3, x + 2 - e0));
        repeat (int'($urandom % 20) + 3) @(negedge clk);
        drive_cap(1'b0, x);
        repeat (3) @(posedge clk);
        rd_reg(2'd3, d);
        check("R5 both fall, wrapped", d, exp_cap(3, x + 2 - e0));
        prevcap = d;

        // R11 reserved edge code 2
        setup(3, 50, 2 << 2);
        repeat (3) @(negedge clk);
        drive_cap(1'b1, x);
        repeat (4) @(negedge clk);
        drive_cap(1'b0, x);
        repeat (4) @(negedge clk);
        check("R11 edge2 no flag", int'(cap_flag), 0);
        rd_reg(2'd3, d);
        check("R11 edge2 no capture", d, prevcap);
        wr_reg(2'd1, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule